// File: doc/BRIEF.md
# Differential Phase Symbol Encoder for Enhanced-Rate Payloads

This block turns a serial payload bit stream into differentially encoded phase symbols for the two enhanced-rate modulations. In quad mode, each symbol carries two bits and the phase steps by an odd multiple of 45 degrees. In octal mode, each symbol carries three bits and the phase steps by any multiple of 45 degrees. The block does not map a bit group to a fixed constellation point. It holds an absolute phase as a 3-bit index k, where the angle is k × 45°, and adds a Gray-coded increment to it modulo 8 on each symbol.

Bits enter through a valid/ready handshake. Once a group of two or three bits is complete, the collector deasserts ready and holds the group until the next symbol strobe. The strobe runs at the 1 MHz symbol rate and comes from the surrounding transmit timing. A start pulse, issued at the beginning of the sync sequence, loads the phase with a reference value and discards any partial group. The phase index and a one-cycle symbol-valid pulse feed the pulse shaper that follows.

Top module: `edr_dpsk_encoder`

## Requirements
- R1: After reset, phase_idx is 0, sym_valid is 0 and bit_ready is 1.
- R2: With mode_oct=0, a group adds a phase step as follows: 00 adds 1 (+45°), 01 adds 3 (+135°), 11 adds 5 (−135°) and 10 adds 7 (−45°).
- R3: With mode_oct=1, a group adds a phase step as follows: 000 adds 0, 001 adds 1, 011 adds 2, 010 adds 3, 110 adds 4, 111 adds 5, 101 adds 6 and 100 adds 7.
- R4: The first bit accepted into a group is the leftmost bit of the pattern in R2/R3.
- R5: The phase index wraps modulo 8. For example, 7 plus a step of 1 gives 0.
- R6: A symbol is produced only on a clock edge where sym_tick is high, the group is complete and start is low. A strobe that arrives with an incomplete group produces no symbol and leaves the phase unchanged.
- R7: bit_ready is low while a complete group waits for its strobe. Bits offered during that time are not taken and do not appear in any later group.
- R8: start loads phase_idx with ref_phase on the next edge and clears any partial group. start takes priority over a simultaneous sym_tick, and no symbol is produced in that cycle.
- R9: sym_valid is a single-cycle pulse that rises one edge after the strobe edge, and phase_idx holds its value between symbols and loads.
- R10: In quad mode, the lowest bit of phase_idx toggles on every symbol, so consecutive symbols alternate between the even and odd point sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_oct | input | 1 | 0: two bits per symbol, 1: three bits per symbol |
| start | input | 1 | Load phase with ref_phase and clear the collector |
| ref_phase | input | 3 | Phase index loaded by start |
| sym_tick | input | 1 | Symbol strobe, one clock wide |
| bit_valid | input | 1 | Payload bit offered |
| bit_data | input | 1 | Payload bit value |
| bit_ready | output | 1 | Collector can take a bit |
| phase_idx | output | 3 | Absolute phase index, angle = index × 45° |
| sym_valid | output | 1 | New symbol on phase_idx this cycle |

## Verification
The assertions assume that mode_oct changes only while the collector is empty. They also assume that start and bit_valid are not raised in the same cycle, and that sym_tick is a single-cycle pulse with at least one idle cycle between strobes. The bench changes the mode only between complete symbols and separates each strobe by at least one low cycle. It raises start only while bit_valid is low, so every property's premise matches the stimulus.

// File: rtl/edr_dpsk_pkg.sv
`timescale 1ns/1ps
package edr_dpsk_pkg;
  localparam int PHASE_W = 3;
  localparam int MAX_GROUP = 3;
  typedef logic [PHASE_W-1:0] phase_t;
  typedef enum logic { MODE_QUAD = 1'b0, MODE_OCT = 1'b1 } dpsk_mode_e;

  // Gray-coded step for two-bit groups (always odd)
  function automatic phase_t step_quad(input logic [1:0] grp);
    case (grp)
      2'b00:   return phase_t'(1);
      2'b01:   return phase_t'(3);
      2'b11:   return phase_t'(5);
      default: return phase_t'(7);
    endcase
  endfunction

  // Gray-coded step for three-bit groups
  function automatic phase_t step_oct(input logic [2:0] grp);
    case (grp)
      3'b000:  return phase_t'(0);
      3'b001:  return phase_t'(1);
      3'b011:  return phase_t'(2);
      3'b010:  return phase_t'(3);
      3'b110:  return phase_t'(4);
      3'b111:  return phase_t'(5);
      3'b101:  return phase_t'(6);
      default: return phase_t'(7);
    endcase
  endfunction

  function automatic phase_t accumulate(input phase_t cur, input phase_t step);
    return cur + step;
  endfunction
endpackage

// File: rtl/dpsk_bit_collector.sv
`timescale 1ns/1ps
module dpsk_bit_collector #(
  parameter int MAX_BITS = 3,
  localparam int CNT_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                mode_oct,
  input  logic                bit_valid,
  input  logic                bit_data,
  input  logic                consume,
  output logic                bit_ready,
  output logic                grp_full,
  output logic [MAX_BITS-1:0] grp
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need;
  logic             take;

  assign need      = mode_oct ? CNT_W'(3) : CNT_W'(2);
  assign grp_full  = (cnt_q >= need);
  assign bit_ready = !grp_full;
  assign take      = bit_valid && bit_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      grp   <= '0;
    end else if (clear || consume) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + CNT_W'(1);
      grp   <= {grp[MAX_BITS-2:0], bit_data};
    end
  end
endmodule

// File: rtl/dpsk_phase_accum.sv
`timescale 1ns/1ps
module dpsk_phase_accum
  import edr_dpsk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  phase_t load_val,
  input  logic   advance,
  input  phase_t step,
  output phase_t phase,
  output logic   valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      valid <= 1'b0;
    end else if (load) begin
      phase <= load_val;
      valid <= 1'b0;
    end else if (advance) begin
      phase <= accumulate(phase, step);
      valid <= 1'b1;
    end else begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/edr_dpsk_encoder.sv
`timescale 1ns/1ps
module edr_dpsk_encoder
  import edr_dpsk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_oct,
  input  logic       start,
  input  logic [2:0] ref_phase,
  input  logic       sym_tick,
  input  logic       bit_valid,
  input  logic       bit_data,
  output logic       bit_ready,
  output logic [2:0] phase_idx,
  output logic       sym_valid
);
  logic [MAX_GROUP-1:0] grp;
  logic                 grp_full;
  logic                 emit;
  phase_t               step;
  dpsk_mode_e           mode;

  assign mode = dpsk_mode_e'(mode_oct);
  assign emit = sym_tick && grp_full && !start;
  assign step = (mode == MODE_OCT) ? step_oct(grp[2:0]) : step_quad(grp[1:0]);

  dpsk_bit_collector #(.MAX_BITS(MAX_GROUP)) collector_i (
    .clk(clk), .rst_n(rst_n), .clear(start), .mode_oct(mode_oct),
    .bit_valid(bit_valid), .bit_data(bit_data), .consume(emit),
    .bit_ready(bit_ready), .grp_full(grp_full), .grp(grp)
  );

  dpsk_phase_accum accum_i (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(ref_phase),
    .advance(emit), .step(step), .phase(phase_idx), .valid(sym_valid)
  );
endmodule

// File: rtl/edr_dpsk_encoder_chk.sv
`timescale 1ns/1ps
module edr_dpsk_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_oct,
  input logic       start,
  input logic [2:0] ref_phase,
  input logic       sym_tick,
  input logic       bit_ready,
  input logic [2:0] phase_idx,
  input logic       sym_valid
);
  // R6: a symbol needs a strobe without start on the previous edge
  a_r6_valid_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> ($past(sym_tick) && !$past(start)));

  // R8: start loads the reference and suppresses the symbol
  a_r8_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (phase_idx == $past(ref_phase) && !sym_valid));

  // R9: phase holds when no symbol and no load happened
  a_r9_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid && !$past(start)) |-> $stable(phase_idx));

  // R10: quad-mode steps are odd
  a_r10_odd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !$past(mode_oct)) |-> (phase_idx[0] != $past(phase_idx[0])));

  // R7: the collector is emptied by an emitted symbol
  a_r7_ready_after_emit: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> bit_ready);

  // R9: no back-to-back symbol pulses under single-cycle strobes
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sym_valid) |-> !sym_valid);
endmodule

bind edr_dpsk_encoder edr_dpsk_encoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_oct(mode_oct), .start(start),
  .ref_phase(ref_phase), .sym_tick(sym_tick), .bit_ready(bit_ready),
  .phase_idx(phase_idx), .sym_valid(sym_valid)
);

// File: tb/edr_dpsk_encoder_tb_top.sv
`timescale 1ns/1ps
module edr_dpsk_encoder_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, mode_oct = 1'b0, start = 1'b0;
  logic       sym_tick = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
  logic [2:0] ref_phase = 3'd0;
  logic       bit_ready, sym_valid;
  logic [2:0] phase_idx;

  int checks = 0, fails = 0, exp_phase = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    mode_q[$];
  logic [2:0] prev_seen = 3'd0;
  bit    finished = 1'b0;
  int    m_exp;
  string m_tag;
  bit    m_mode;

  always #2.5 clk = ~clk;

  edr_dpsk_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .mode_oct(mode_oct), .start(start),
    .ref_phase(ref_phase), .sym_tick(sym_tick), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .phase_idx(phase_idx),
    .sym_valid(sym_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent model: degrees from the requirement tables
  function automatic int step_of(input bit m, input logic [2:0] g);
    int deg;
    if (!m) begin
      case (g[1:0])
        2'b00: deg = 45;  2'b01: deg = 135;
        2'b11: deg = -135; default: deg = -45;
      endcase
    end else begin
      case (g)
        3'b000: deg = 0;    3'b001: deg = 45;  3'b011: deg = 90;
        3'b010: deg = 135;  3'b110: deg = 180; 3'b111: deg = -135;
        3'b101: deg = -90;  default: deg = -45;
      endcase
    end
    return ((deg + 360) / 45) % 8;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (sym_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected symbol", int'(phase_idx), -1);
        end else begin
          m_exp  = exp_q.pop_front();
          m_tag  = tag_q.pop_front();
          m_mode = mode_q.pop_front();
          chk(int'(phase_idx) == m_exp, m_tag, int'(phase_idx), m_exp);
          if (!m_mode)
            chk(phase_idx[0] != prev_seen[0], "R10 parity alternation",
                int'(phase_idx[0]), int'(!prev_seen[0]));
        end
      end
      prev_seen = phase_idx;
    end
  end

  task automatic push_bit(input bit b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = b;
    while (!bit_ready) @(negedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sym_tick = 1'b1;
    @(negedge clk);
    sym_tick = 1'b0;
  endtask

  task automatic expect_sym(input bit m, input logic [2:0] g, input string tag);
    exp_phase = (exp_phase + step_of(m, g)) % 8;
    exp_q.push_back(exp_phase);
    tag_q.push_back(tag);
    mode_q.push_back(m);
  endtask

  task automatic send_group(input bit m, input logic [2:0] g, input string tag);
    mode_oct = m;
    for (int i = (m ? 2 : 1); i >= 0; i--) push_bit(g[i]);
    expect_sym(m, g, tag);
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(phase_idx == 3'd0, "R1 phase after reset", int'(phase_idx), 0);
    chk(sym_valid == 1'b0, "R1 valid after reset", int'(sym_valid), 0);
    chk(bit_ready == 1'b1, "R1 ready after reset", int'(bit_ready), 1);
    rst_n = 1'b1;

    // R2 all quad entries; R4 via 01 versus 10
    send_group(1'b0, 3'b000, "R2 quad 00");
    send_group(1'b0, 3'b001, "R2 quad 01 (R4 order)");
    send_group(1'b0, 3'b011, "R2 quad 11");
    send_group(1'b0, 3'b010, "R2 quad 10 (R4 order)");
    // R3 all octal entries; R4 via 011 versus 110
    for (int g = 0; g < 8; g++) send_group(1'b1, 3'(g), "R3 octal table");
    send_group(1'b1, 3'b110, "R3 octal 110 (R4 order)");
    send_group(1'b1, 3'b011, "R3 octal 011 (R4 order)");

    // R9 pulse width and hold
    @(negedge clk);
    chk(sym_valid == 1'b0, "R9 single pulse", int'(sym_valid), 0);
    chk(int'(phase_idx) == exp_phase, "R9 phase holds", int'(phase_idx), exp_phase);

    // R6 strobe with incomplete group
    mode_oct = 1'b0;
    push_bit(1'b1);
    tick();
    chk(sym_valid == 1'b0, "R6 no symbol on partial group", int'(sym_valid), 0);
    chk(int'(phase_idx) == exp_phase, "R6 phase unchanged", int'(phase_idx), exp_phase);
    push_bit(1'b0);
    expect_sym(1'b0, 3'b010, "R6 group completes after late bit");
    tick();

    // R7 bits refused while group waits
    push_bit(1'b0);
    push_bit(1'b1);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(bit_ready == 1'b0, "R7 ready low while full", int'(bit_ready), 0);
    end
    bit_valid = 1'b0;
    expect_sym(1'b0, 3'b001, "R7 held group intact");
    tick();
    send_group(1'b0, 3'b000, "R7 no stray bit taken");

    // R8 start beats strobe with full group
    push_bit(1'b1);
    push_bit(1'b1);
    @(negedge clk);
    start = 1'b1; ref_phase = 3'd5; sym_tick = 1'b1;
    @(negedge clk);
    start = 1'b0; sym_tick = 1'b0;
    chk(phase_idx == 3'd5, "R8 reference loaded", int'(phase_idx), 5);
    chk(sym_valid == 1'b0, "R8 start suppresses symbol", int'(sym_valid), 0);
    chk(bit_ready == 1'b1, "R8 group cleared", int'(bit_ready), 1);
    exp_phase = 5;
    send_group(1'b0, 3'b000, "R8 first symbol after load");

    // R8 partial discard then R5 wrap 7 -> 0
    mode_oct = 1'b1;
    push_bit(1'b1);
    push_bit(1'b0);
    @(negedge clk);
    start = 1'b1; ref_phase = 3'd7;
    @(negedge clk);
    start = 1'b0;
    exp_phase = 7;
    send_group(1'b1, 3'b001, "R5 wrap 7+1 (R8 partial discarded)");
    @(negedge clk);
    start = 1'b1; ref_phase = 3'd6;
    @(negedge clk);
    start = 1'b0;
    exp_phase = 6;
    send_group(1'b0, 3'b001, "R5 wrap 6+3");

    // R10 long quad run, then mixed octal run
    for (int i = 0; i < 24; i++) send_group(1'b0, 3'((i * 3 + i / 4) % 4), "R10 quad run");
    for (int i = 0; i < 24; i++) send_group(1'b1, 3'((i * 5 + 3) % 8), "R3 octal run");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 missing symbols", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule